// File: doc/BRIEF.md
# General-Purpose I/O Port Register Block

This block is the register side of one general-purpose I/O port on a small controller bus. It holds two software registers: a direction register and a port data register. A third address gives a read-only view of the levels at the pads. For every pin the block drives three pad controls: an output value, an output enable and a pull-up enable. The direction bit picks the meaning of the data bit. A pin set as an output drives the data bit onto the pad. A pin set as an input turns its pull-up on when its data bit is one.

The bus takes one access per clock. A write lands at the clock edge and read data is returned combinationally for the address on the bus. Each register answers at two addresses: a base I/O offset and an alias placed a fixed step above it. A write to the input-view address does not store anything. Each one in the written byte inverts the matching data bit, which gives software a single-access way to flip output levels. Pad levels reach the input view through a two-stage synchronizer. The port width is a parameter, and any bit above the implemented pin count is reserved.

Top module: `gpio_port_regs`

## Requirements
- R1: After reset, both registers are zero. Every pin is an input, with pad_oe, pad_out and pad_pu all zero, and every register reads back zero.
- R2: A write to the direction register (offset 0x13, alias 0x33) stores the byte. Reads return it, and pad_oe equals it from the next clock. A one bit means output.
- R3: A write to the port data register (offset 0x14, alias 0x34) stores the byte, and reads return it.
- R4: For each pin, pad_out equals the data bit when the direction bit is one, and is zero when the direction bit is zero.
- R5: For each pin, pad_pu is one exactly when the direction bit is zero and the data bit is one.
- R6: A read of the input view (offset 0x0F, alias 0x2F) returns the pad levels whatever the direction bits hold. A change at pad_in shows there after exactly two rising clock edges.
- R7: A write to the input-view address inverts each data bit whose written bit is one. It leaves data bits under a written zero unchanged, and it leaves the direction register unchanged.
- R8: Bits at or above PIN_COUNT (bits 7:6 with the default of 6 pins) always read zero in every register. Writing ones to them changes no register and no pad output.
- R9: A read of any address that is not mapped returns zero, and a write to such an address changes no register and no pad output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_addr | input | ADDR_W | Register address |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pad_in | input | PIN_COUNT | Raw pad levels, asynchronous |
| pad_out | output | PIN_COUNT | Output level per pin |
| pad_oe | output | PIN_COUNT | Output enable per pin |
| pad_pu | output | PIN_COUNT | Pull-up enable per pin |

## Verification
A corrupted data or direction bit shows on the pad controls in the cycle after the faulty write. The union of pad_out and pad_pu equals the data register, and pad_oe equals the direction register, so both registers can be seen at the ports at all times. A synchronizer fault shows as a read of the input view that comes one cycle early or late, or that holds a stale level. Decode faults show as a register that changes after a write to an unrelated or unmapped address, or as nonzero read data from an empty address.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int DATA_W = 8;

    typedef struct packed {
        logic [DATA_W-1:0] port;
        logic [DATA_W-1:0] dir;
    } gpio_regs_t;

    typedef struct packed {
        logic port;
        logic dir;
        logic pin;
    } gpio_sel_t;

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int PORT_OFS   = 'h14,
    parameter int DIR_OFS    = 'h13,
    parameter int PIN_OFS    = 'h0F,
    parameter int ALIAS_STEP = 'h20
) (
    input  logic [ADDR_W-1:0] addr,
    output gpio_sel_t         sel
);

    localparam logic [ADDR_W-1:0] PORT_A = ADDR_W'(PORT_OFS);
    localparam logic [ADDR_W-1:0] PORT_B = ADDR_W'(PORT_OFS + ALIAS_STEP);
    localparam logic [ADDR_W-1:0] DIR_A  = ADDR_W'(DIR_OFS);
    localparam logic [ADDR_W-1:0] DIR_B  = ADDR_W'(DIR_OFS + ALIAS_STEP);
    localparam logic [ADDR_W-1:0] PIN_A  = ADDR_W'(PIN_OFS);
    localparam logic [ADDR_W-1:0] PIN_B  = ADDR_W'(PIN_OFS + ALIAS_STEP);

    always_comb begin
        sel.port = (addr == PORT_A) || (addr == PORT_B);
        sel.dir  = (addr == DIR_A)  || (addr == DIR_B);
        sel.pin  = (addr == PIN_A)  || (addr == PIN_B);
    end

endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int W      = 6,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [W-1:0] stage_d [STAGES];
    logic [W-1:0] stage_q [STAGES];

    genvar s;
    generate
        for (s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb stage_d[s] = async_in;
            end else begin : g_next
                always_comb stage_d[s] = stage_q[s-1];
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stage_q[s] <= '0;
                else        stage_q[s] <= stage_d[s];
            end
        end
    endgenerate

    assign sync_out = stage_q[STAGES-1];

endmodule

// File: rtl/gpio_pad_ctrl.sv
module gpio_pad_ctrl #(
    parameter int PIN_COUNT = 6
) (
    input  logic [PIN_COUNT-1:0] port_bits,
    input  logic [PIN_COUNT-1:0] dir_bits,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_pu
);

    genvar i;
    generate
        for (i = 0; i < PIN_COUNT; i++) begin : g_pin
            always_comb begin
                pad_oe[i]  = dir_bits[i];
                pad_out[i] = dir_bits[i] & port_bits[i];
                pad_pu[i]  = ~dir_bits[i] & port_bits[i];
            end
        end
    endgenerate

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int PIN_COUNT  = 6,
    parameter int ADDR_W     = 8,
    parameter int PORT_OFS   = 'h14,
    parameter int DIR_OFS    = 'h13,
    parameter int PIN_OFS    = 'h0F,
    parameter int ALIAS_STEP = 'h20,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [ADDR_W-1:0]    bus_addr,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    input  logic [PIN_COUNT-1:0] pad_in,
    output logic [PIN_COUNT-1:0] pad_out,
    output logic [PIN_COUNT-1:0] pad_oe,
    output logic [PIN_COUNT-1:0] pad_pu
);

    localparam logic [DATA_W-1:0] PIN_MASK = DATA_W'((1 << PIN_COUNT) - 1);

    gpio_sel_t          sel;
    gpio_regs_t         regs_d;
    gpio_regs_t         regs_q;
    logic [PIN_COUNT-1:0] pin_sync;
    logic [DATA_W-1:0]  wr_bits;

    gpio_addr_decode #(
        .ADDR_W    (ADDR_W),
        .PORT_OFS  (PORT_OFS),
        .DIR_OFS   (DIR_OFS),
        .PIN_OFS   (PIN_OFS),
        .ALIAS_STEP(ALIAS_STEP)
    ) u_decode (
        .addr(bus_addr),
        .sel (sel)
    );

    gpio_sync #(
        .W     (PIN_COUNT),
        .STAGES(SYNC_DEPTH)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_in(pad_in),
        .sync_out(pin_sync)
    );

    // Next-state: reserved bits are masked away before they reach storage.
    always_comb begin
        regs_d  = regs_q;
        wr_bits = bus_wdata & PIN_MASK;
        if (bus_wr) begin
            if (sel.port)      regs_d.port = wr_bits;
            else if (sel.dir)  regs_d.dir  = wr_bits;
            else if (sel.pin)  regs_d.port = regs_q.port ^ wr_bits;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        bus_rdata = '0;
        if (sel.port)     bus_rdata = regs_q.port & PIN_MASK;
        else if (sel.dir) bus_rdata = regs_q.dir & PIN_MASK;
        else if (sel.pin) bus_rdata = DATA_W'(pin_sync);
    end

    gpio_pad_ctrl #(
        .PIN_COUNT(PIN_COUNT)
    ) u_pad (
        .port_bits(regs_q.port[PIN_COUNT-1:0]),
        .dir_bits (regs_q.dir[PIN_COUNT-1:0]),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .pad_pu   (pad_pu)
    );

endmodule

// File: rtl/gpio_port_regs_chk.sv
module gpio_port_regs_chk #(
    parameter int PIN_COUNT  = 6,
    parameter int ADDR_W     = 8,
    parameter int PORT_OFS   = 'h14,
    parameter int DIR_OFS    = 'h13,
    parameter int PIN_OFS    = 'h0F,
    parameter int ALIAS_STEP = 'h20
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [ADDR_W-1:0]    bus_addr,
    input logic                 bus_wr,
    input logic [7:0]           bus_wdata,
    input logic [7:0]           bus_rdata,
    input logic [PIN_COUNT-1:0] pad_in,
    input logic [PIN_COUNT-1:0] pad_out,
    input logic [PIN_COUNT-1:0] pad_oe,
    input logic [PIN_COUNT-1:0] pad_pu
);

    localparam logic [7:0] MASK = 8'((1 << PIN_COUNT) - 1);

    logic hit_port, hit_dir, hit_pin;
    logic [PIN_COUNT-1:0] data_view;
    logic [1:0] age_q;

    assign hit_port  = (bus_addr == ADDR_W'(PORT_OFS)) || (bus_addr == ADDR_W'(PORT_OFS + ALIAS_STEP));
    assign hit_dir   = (bus_addr == ADDR_W'(DIR_OFS))  || (bus_addr == ADDR_W'(DIR_OFS + ALIAS_STEP));
    assign hit_pin   = (bus_addr == ADDR_W'(PIN_OFS))  || (bus_addr == ADDR_W'(PIN_OFS + ALIAS_STEP));
    assign data_view = pad_out | pad_pu;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              age_q <= 2'd0;
        else if (age_q != 2'd3)  age_q <= age_q + 2'd1;
    end

    p_dir_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_dir) |=> pad_oe == $past(bus_wdata[PIN_COUNT-1:0]));

    p_data_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_port) |=> data_view == $past(bus_wdata[PIN_COUNT-1:0]));

    p_out_only_when_enabled_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_out & ~pad_oe) == '0);

    p_pull_only_on_inputs_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (pad_pu & pad_oe) == '0);

    p_sync_latency_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd3 && hit_pin) |-> bus_rdata[PIN_COUNT-1:0] == $past(pad_in, 2));

    p_toggle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && hit_pin) |=> (data_view == ($past(data_view) ^ $past(bus_wdata[PIN_COUNT-1:0])))
                                && $stable(pad_oe));

    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_rdata & ~MASK) == 8'h00);

    p_quiet_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && (hit_port || hit_dir || hit_pin)) |=> $stable(pad_oe) && $stable(data_view));

    p_unmapped_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(hit_port || hit_dir || hit_pin) |-> bus_rdata == 8'h00);

endmodule

bind gpio_port_regs gpio_port_regs_chk #(
    .PIN_COUNT (PIN_COUNT),
    .ADDR_W    (ADDR_W),
    .PORT_OFS  (PORT_OFS),
    .DIR_OFS   (DIR_OFS),
    .PIN_OFS   (PIN_OFS),
    .ALIAS_STEP(ALIAS_STEP)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_addr (bus_addr),
    .bus_wr   (bus_wr),
    .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata),
    .pad_in   (pad_in),
    .pad_out  (pad_out),
    .pad_oe   (pad_oe),
    .pad_pu   (pad_pu)
);

// File: tb/gpio_port_regs_tb.sv
`timescale 1ns/1ps
module gpio_port_regs_tb;

    localparam int NP = 6;
    localparam logic [7:0] MSK = 8'h3F;
    localparam logic [7:0] A_PORT = 8'h14, A_PORT2 = 8'h34;
    localparam logic [7:0] A_DIR  = 8'h13, A_DIR2  = 8'h33;
    localparam logic [7:0] A_PIN  = 8'h0F, A_PIN2  = 8'h2F;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [7:0]    bus_addr = 8'h00;
    logic          bus_wr = 1'b0;
    logic [7:0]    bus_wdata = 8'h00;
    logic [7:0]    bus_rdata;
    logic [NP-1:0] pad_in = '0;
    logic [NP-1:0] pad_out, pad_oe, pad_pu;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    logic [7:0] m_port = 8'h00;
    logic [7:0] m_dir  = 8'h00;

    always #10 clk = ~clk;

    gpio_port_regs u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .pad_pu(pad_pu)
    );

    function automatic logic [7:0] exp_out(input logic [7:0] p, input logic [7:0] d);
        return p & d & MSK;
    endfunction

    function automatic logic [7:0] exp_pu(input logic [7:0] p, input logic [7:0] d);
        return p & ~d & MSK;
    endfunction

    function automatic bit is_mapped(input logic [7:0] a);
        return a == A_PORT || a == A_PORT2 || a == A_DIR || a == A_DIR2 || a == A_PIN || a == A_PIN2;
    endfunction

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; bus_addr = 8'h00;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [7:0] d);
        bus_addr = a;
        #2;
        d = bus_rdata;
    endtask

    task automatic chk_pads(input string req);
        chk({req, " oe"},  8'(pad_oe),  m_dir & MSK);
        chk({req, " out"}, 8'(pad_out), exp_out(m_port, m_dir));
        chk({req, " pu"},  8'(pad_pu),  exp_pu(m_port, m_dir));
    endtask

    initial begin
        logic [7:0] rd;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk_pads("R1");
        bus_read(A_PORT, rd); chk("R1 port read", rd, 8'h00);
        bus_read(A_DIR, rd);  chk("R1 dir read", rd, 8'h00);
        bus_read(A_PIN, rd);  chk("R1 pin read", rd, 8'h00);
        @(negedge clk); rst_n = 1'b1;

        // R2 / R3 directed, both aliases
        bus_write(A_DIR, 8'h0F); m_dir = 8'h0F;
        chk_pads("R2");
        bus_read(A_DIR2, rd); chk("R2 alias read", rd, 8'h0F);
        bus_write(A_PORT2, 8'h35); m_port = 8'h35;
        bus_read(A_PORT, rd); chk("R3 read", rd, 8'h35);
        chk_pads("R4 R5 mixed");

        // R8: reserved bits
        bus_write(A_PORT, 8'hC0); m_port = 8'h00;
        bus_read(A_PORT, rd); chk("R8 port reserved", rd, 8'h00);
        chk_pads("R8 pads");
        bus_write(A_DIR2, 8'hFF); m_dir = 8'h3F;
        bus_read(A_DIR, rd); chk("R8 dir reserved", rd, 8'h3F);

        // R7: toggle through the input-view address
        bus_write(A_PORT, 8'h2A); m_port = 8'h2A;
        bus_write(A_PIN, 8'h0F); m_port = 8'h25;
        bus_read(A_PORT, rd); chk("R7 toggle", rd, 8'h25);
        bus_read(A_DIR, rd);  chk("R7 dir kept", rd, 8'h3F);
        chk_pads("R7 pads");
        bus_write(A_PIN2, 8'hC0);
        bus_read(A_PORT, rd); chk("R7 reserved toggle", rd, 8'h25);

        // R6: latency of exactly two edges, outputs set
        pad_in = 6'h00;
        repeat (3) @(negedge clk);
        pad_in = 6'h2D;
        @(negedge clk); bus_read(A_PIN, rd); chk("R6 one edge", rd, 8'h00);
        @(negedge clk); bus_read(A_PIN, rd); chk("R6 two edges", rd, 8'h2D);
        bus_write(A_DIR, 8'h00); m_dir = 8'h00;
        bus_read(A_PIN2, rd); chk("R6 inputs", rd, 8'h2D);
        chk_pads("R5 inputs");

        // R9: unmapped addresses
        bus_write(8'h15, 8'hFF);
        bus_write(8'h00, 8'hFF);
        bus_write(8'hAF, 8'hFF);
        chk_pads("R9 write");
        bus_read(8'h15, rd); chk("R9 read", rd, 8'h00);
        bus_read(8'h0E, rd); chk("R9 read low", rd, 8'h00);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            int op;
            logic [7:0] d;
            logic [7:0] a;
            op = int'($urandom % 5);
            d  = 8'($urandom);
            case (op)
                0: begin a = ($urandom % 2) ? A_PORT : A_PORT2;
                         bus_write(a, d); m_port = d & MSK;
                         bus_read(a, rd); chk("R3 rand", rd, m_port); end
                1: begin a = ($urandom % 2) ? A_DIR : A_DIR2;
                         bus_write(a, d); m_dir = d & MSK;
                         bus_read(a, rd); chk("R2 rand", rd, m_dir); end
                2: begin a = ($urandom % 2) ? A_PIN : A_PIN2;
                         bus_write(a, d); m_port = (m_port ^ d) & MSK;
                         bus_read(A_PORT, rd); chk("R7 rand", rd, m_port); end
                3: begin a = 8'($urandom);
                         if (is_mapped(a)) a = 8'h50;
                         bus_write(a, d);
                         bus_read(a, rd); chk("R9 rand", rd, 8'h00); end
                default: begin
                         @(negedge clk); pad_in = NP'($urandom);
                         repeat (2) @(negedge clk);
                         bus_read(A_PIN, rd); chk("R6 rand", rd, 8'(pad_in)); end
            endcase
            chk_pads("R4 R5 rand");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule